// File: doc/BRIEF.md
# Four-Event Edge Timestamp Unit

The block measures the timing of transitions on one input pin. A free-running counter advances once per clock. Capture events occur in a fixed cycle: event 0, then 1, 2 and 3. When the pending event's edge arrives, the block copies the counter into that event's timestamp register. It also raises a one-cycle flag that carries the event's index.

Each event has its own edge sense. Each event can also clear the counter right after its capture, which gives period and pulse-width measurement in delta form. Without that clear, the stamps are absolute times.

Several controls shape the sequence. A prescaler can thin out the qualifying edges before capture. A stop selector sets the last event of the cycle. In one-shot mode the unit freezes after that last event until a re-arm pulse restarts it. Timestamp writes can be switched off while the event flags keep firing.

Top module: `edge_stamp_unit`

## Requirements
- R1: Synchronous reset clears all four timestamps and the counter, drops the event flag, and makes event 0 the pending event.
- R2: Each event has a polarity bit in `pol_sel[k]`: 0 captures on a rising edge of the pin, 1 on a falling edge. Only the pending event's polarity is evaluated.
- R3: If `clr_on_ev[k]` is set when event k fires, the timestamp stores the counter value before the clear, and the counter reads 0 in the next cycle. A following event D cycles later stores D-1.
- R4: If the clear bit of an event is 0, the counter keeps running. Two events whose pin edges are D cycles apart store timestamps that differ by exactly D.
- R5: While `load_en` is 0, events leave all timestamps unchanged but still produce event flags and still advance the sequence.
- R6: A prescale code N of 1 to 31 lets one event through per 2·N qualifying edges. Code 0 passes every qualifying edge.
- R7: The events run in order 0,1,2,3. After the event whose index equals `stop_sel`, the sequence wraps to event 0.
- R8: With `one_shot` = 1, the sequence freezes after the `stop_sel` event, and further edges produce no flag and no timestamp write.
- R9: A one-cycle `rearm` pulse returns the sequence to event 0, unfreezes it, and clears the prescaler's edge count.
- R10: Each event gives `ev_pulse` high for exactly one cycle, with `ev_idx` holding the 2-bit index of the event that fired.
- R11: The pin passes through two synchronizer flip-flops. A pin change set up before clock edge 1 raises `ev_pulse` in the cycle after clock edge 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous pin being timed |
| pol_sel | input | 4 | Per-event edge sense, 0 rising, 1 falling |
| clr_on_ev | input | 4 | Per-event clear of the counter after capture |
| load_en | input | 1 | Enables timestamp register writes |
| ps_code | input | 5 | Prescale code N, divide by 2·N, 0 bypasses |
| one_shot | input | 1 | 1 freezes after the stop event, 0 wraps |
| stop_sel | input | 2 | Index of the last event of the cycle |
| rearm | input | 1 | One-cycle restart of the sequence and prescaler |
| stamp_0 | output | 32 | Timestamp of event 0 |
| stamp_1 | output | 32 | Timestamp of event 1 |
| stamp_2 | output | 32 | Timestamp of event 2 |
| stamp_3 | output | 32 | Timestamp of event 3 |
| ev_pulse | output | 1 | One-cycle event flag |
| ev_idx | output | 2 | Index of the event flagged |

## Verification
A sequencer that is off by one shows on the very next flag as a wrong `ev_idx`. It also puts the stamp into the wrong register, so differences between neighbouring stamps stop matching the pin's edge spacing. A counter that is cleared a cycle late or too early shifts every delta stamp by one, and this is visible as soon as the next event lands. A prescaler count that is not cleared on re-arm shows up as an event flag arriving before the 2·N-th edge after the restart.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int EV_NUM = 4;
  localparam int IDX_W  = $clog2(EV_NUM);
  typedef logic [IDX_W-1:0] ev_idx_t;
endpackage

// File: rtl/stamp_edge_sync.sv
module stamp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  // chain[0..STAGES-1] synchronizer, chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign rise =  chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/stamp_prescale.sv
module stamp_prescale #(
  parameter int PS_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [PS_W-1:0] code,
  input  logic            edge_in,
  output logic            edge_out
);
  localparam int CW = PS_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;
  logic          bypass;
  logic          at_last;

  assign bypass   = (code == '0);
  assign last     = {code, 1'b0} - CW'(1);
  assign at_last  = (cnt_q >= last);
  assign edge_out = edge_in & (bypass | at_last);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (edge_in && !bypass)
      cnt_q <= at_last ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/stamp_sequencer.sv
module stamp_sequencer
  import stamp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rearm,
  input  logic    one_shot,
  input  ev_idx_t stop_sel,
  input  logic    adv,
  output ev_idx_t cur_idx,
  output logic    frozen
);
  always_ff @(posedge clk) begin
    if (rst || rearm) begin
      cur_idx <= '0;
      frozen  <= 1'b0;
    end else if (adv) begin
      if (cur_idx == stop_sel) begin
        cur_idx <= '0;
        frozen  <= one_shot;
      end else begin
        cur_idx <= cur_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_stamp_unit.sv
module edge_stamp_unit
  import stamp_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PS_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_in,
  input  logic [EV_NUM-1:0] pol_sel,
  input  logic [EV_NUM-1:0] clr_on_ev,
  input  logic              load_en,
  input  logic [PS_W-1:0]   ps_code,
  input  logic              one_shot,
  input  logic [IDX_W-1:0]  stop_sel,
  input  logic              rearm,
  output logic [CNT_W-1:0]  stamp_0,
  output logic [CNT_W-1:0]  stamp_1,
  output logic [CNT_W-1:0]  stamp_2,
  output logic [CNT_W-1:0]  stamp_3,
  output logic              ev_pulse,
  output logic [IDX_W-1:0]  ev_idx
);
  logic       pin_rise, pin_fall;
  logic       pend_edge, qual_edge, ev_fire;
  ev_idx_t    cur_idx;
  logic       frozen;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] stamp_q [EV_NUM];

  stamp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pin_in),
    .rise(pin_rise),
    .fall(pin_fall)
  );

  // edge sense is taken from the event currently pending
  assign pend_edge = pol_sel[cur_idx] ? pin_fall : pin_rise;
  assign qual_edge = pend_edge & ~frozen & ~rearm;

  stamp_prescale #(.PS_W(PS_W)) u_ps (
    .clk     (clk),
    .rst     (rst),
    .clr     (rearm),
    .code    (ps_code),
    .edge_in (qual_edge),
    .edge_out(ev_fire)
  );

  stamp_sequencer u_seq (
    .clk     (clk),
    .rst     (rst),
    .rearm   (rearm),
    .one_shot(one_shot),
    .stop_sel(stop_sel),
    .adv     (ev_fire),
    .cur_idx (cur_idx),
    .frozen  (frozen)
  );

  // free-running counter; a clearing capture stores the old value first
  always_ff @(posedge clk) begin
    if (rst)                                cnt_q <= '0;
    else if (ev_fire && clr_on_ev[cur_idx]) cnt_q <= '0;
    else                                    cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar g = 0; g < EV_NUM; g++) begin : g_stamp
    always_ff @(posedge clk) begin
      if (rst)
        stamp_q[g] <= '0;
      else if (ev_fire && load_en && (cur_idx == ev_idx_t'(g)))
        stamp_q[g] <= cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_pulse <= 1'b0;
      ev_idx   <= '0;
    end else begin
      ev_pulse <= ev_fire;
      ev_idx   <= cur_idx;
    end
  end

  assign stamp_0 = stamp_q[0];
  assign stamp_1 = stamp_q[1];
  assign stamp_2 = stamp_q[2];
  assign stamp_3 = stamp_q[3];
endmodule

// File: rtl/edge_stamp_unit_chk.sv
module edge_stamp_unit_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       clr_on_ev,
  input logic             load_en,
  input logic [1:0]       stop_sel,
  input logic             rearm,
  input logic             ev_fire,
  input logic [1:0]       cur_idx,
  input logic             frozen,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] stamp_0,
  input logic [CNT_W-1:0] stamp_1,
  input logic [CNT_W-1:0] stamp_2,
  input logic [CNT_W-1:0] stamp_3,
  input logic             ev_pulse,
  input logic [1:0]       ev_idx
);
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    ev_fire && clr_on_ev[cur_idx] |=> cnt_q == '0);

  p_run_r4: assert property (@(posedge clk) disable iff (rst)
    !(ev_fire && clr_on_ev[cur_idx]) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_no_load_r5: assert property (@(posedge clk) disable iff (rst)
    ev_fire && !load_en |=> $stable(stamp_0) && $stable(stamp_1)
                            && $stable(stamp_2) && $stable(stamp_3));

  p_step_r7: assert property (@(posedge clk) disable iff (rst)
    ev_fire && !rearm && cur_idx != stop_sel |=> cur_idx == $past(cur_idx) + 2'd1);

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    ev_fire && !rearm && cur_idx == stop_sel |=> cur_idx == 2'd0);

  p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    frozen && !rearm |=> !ev_pulse);

  p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    rearm |=> cur_idx == 2'd0 && !frozen);

  p_flag_r10: assert property (@(posedge clk) disable iff (rst)
    ev_fire |=> ev_pulse && ev_idx == $past(cur_idx));

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !ev_fire |=> !ev_pulse);
endmodule

bind edge_stamp_unit edge_stamp_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_on_ev(clr_on_ev),
  .load_en  (load_en),
  .stop_sel (stop_sel),
  .rearm    (rearm),
  .ev_fire  (ev_fire),
  .cur_idx  (cur_idx),
  .frozen   (frozen),
  .cnt_q    (cnt_q),
  .stamp_0  (stamp_0),
  .stamp_1  (stamp_1),
  .stamp_2  (stamp_2),
  .stamp_3  (stamp_3),
  .ev_pulse (ev_pulse),
  .ev_idx   (ev_idx)
);

// File: tb/test_edge_stamp_unit.sv
module test_edge_stamp_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_in = 1'b0;
  logic [3:0]  pol_sel = '0;
  logic [3:0]  clr_on_ev = '0;
  logic        load_en = 1'b1;
  logic [4:0]  ps_code = '0;
  logic        one_shot = 1'b0;
  logic [1:0]  stop_sel = 2'd3;
  logic        rearm = 1'b0;
  logic [31:0] stamp_0, stamp_1, stamp_2, stamp_3;
  logic        ev_pulse;
  logic [1:0]  ev_idx;

  int n_chk = 0;
  int n_err = 0;
  int n_pulse = 0;
  logic [1:0] plog [1024];

  always #2 clk = ~clk;

  edge_stamp_unit i_edge_stamp_unit (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pol_sel(pol_sel),
    .clr_on_ev(clr_on_ev), .load_en(load_en), .ps_code(ps_code),
    .one_shot(one_shot), .stop_sel(stop_sel), .rearm(rearm),
    .stamp_0(stamp_0), .stamp_1(stamp_1), .stamp_2(stamp_2), .stamp_3(stamp_3),
    .ev_pulse(ev_pulse), .ev_idx(ev_idx)
  );

  always @(negedge clk) begin
    if (!rst && ev_pulse) begin
      plog[n_pulse % 1024] = ev_idx;
      n_pulse = n_pulse + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    pin_in = 1'b1;
    repeat (hi) @(negedge clk);
    pin_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic do_rearm();
    idle(6);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base;
    logic [31:0] s0, s1, s2, s3;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 stamp_0", stamp_0, 0);
    chk("R1 stamp_3", stamp_3, 0);
    chk("R1 ev_pulse", {31'd0, ev_pulse}, 0);
    idle(10);

    // R11 / R10 latency and pulse width, first event must be index 0 (R1)
    pin_in = 1'b1;
    @(negedge clk); chk("R11 no flag after edge 1", {31'd0, ev_pulse}, 0);
    @(negedge clk); chk("R11 no flag after edge 2", {31'd0, ev_pulse}, 0);
    @(negedge clk); chk("R11 flag after edge 3", {31'd0, ev_pulse}, 1);
    chk("R1 first index", {30'd0, ev_idx}, 0);
    @(negedge clk); chk("R10 one-cycle flag", {31'd0, ev_pulse}, 0);
    pin_in = 1'b0;

    // R4 R7 R10 absolute stamps, all rising
    do_rearm();
    base = n_pulse;
    repeat (4) pulse(10, 10);
    idle(8);
    chk("R10 flag count", n_pulse - base, 4);
    for (int k = 0; k < 4; k++) chk("R7 order", {30'd0, plog[(base + k) % 1024]}, k);
    chk("R4 delta 1-0", stamp_1 - stamp_0, 20);
    chk("R4 delta 2-1", stamp_2 - stamp_1, 20);
    chk("R4 delta 3-2", stamp_3 - stamp_2, 20);

    // R2 mixed polarity: events 1 and 3 on falling edges
    pol_sel = 4'b1010;
    do_rearm();
    repeat (2) pulse(7, 13);
    idle(8);
    chk("R2 rise to fall", stamp_1 - stamp_0, 7);
    chk("R2 fall to rise", stamp_2 - stamp_1, 13);
    chk("R2 rise to fall b", stamp_3 - stamp_2, 7);
    pol_sel = 4'b0000;

    // R3 clear on every event
    clr_on_ev = 4'b1111;
    do_rearm();
    repeat (4) pulse(10, 10);
    idle(8);
    chk("R3 delta stamp_1", stamp_1, 19);
    chk("R3 delta stamp_2", stamp_2, 19);
    chk("R3 delta stamp_3", stamp_3, 19);

    // R3 and R4 mixed: only event 1 clears
    clr_on_ev = 4'b0010;
    do_rearm();
    repeat (4) pulse(10, 10);
    idle(8);
    chk("R4 before clear", stamp_1 - stamp_0, 20);
    chk("R3 after clear", stamp_2, 19);
    chk("R3 keeps running", stamp_3, 39);
    clr_on_ev = 4'b0000;

    // R5 load disabled
    s0 = stamp_0; s1 = stamp_1; s2 = stamp_2; s3 = stamp_3;
    load_en = 1'b0;
    do_rearm();
    base = n_pulse;
    repeat (4) pulse(9, 9);
    idle(8);
    chk("R5 flags still fire", n_pulse - base, 4);
    chk("R5 stamp_0 held", stamp_0, s0);
    chk("R5 stamp_1 held", stamp_1, s1);
    chk("R5 stamp_2 held", stamp_2, s2);
    chk("R5 stamp_3 held", stamp_3, s3);
    chk("R5 sequence advanced", {30'd0, plog[(base + 3) % 1024]}, 3);
    load_en = 1'b1;

    // R6 prescale sweep
    for (int n = 1; n <= 7; n++) begin
      ps_code = (n == 7) ? 5'd31 : 5'(n);
      do_rearm();
      base = n_pulse;
      repeat (4 * int'(ps_code)) pulse(3, 3);
      idle(8);
      chk("R6 events per 4N edges", n_pulse - base, 2);
      chk("R6 spacing 2N edges", stamp_1 - stamp_0, 12 * int'(ps_code));
    end

    // R9 rearm clears the prescaler count
    ps_code = 5'd2;
    do_rearm();
    base = n_pulse;
    repeat (3) pulse(3, 3);
    idle(6);
    chk("R6 below ratio", n_pulse - base, 0);
    do_rearm();
    repeat (3) pulse(3, 3);
    idle(6);
    chk("R9 prescaler restarted", n_pulse - base, 0);
    pulse(3, 3);
    idle(6);
    chk("R9 fires on 4th edge", n_pulse - base, 1);
    ps_code = 5'd0;

    // R7 early wrap
    stop_sel = 2'd1;
    do_rearm();
    base = n_pulse;
    repeat (4) pulse(5, 5);
    idle(8);
    chk("R7 wrap count", n_pulse - base, 4);
    chk("R7 wrap idx2", {30'd0, plog[(base + 2) % 1024]}, 0);
    chk("R7 wrap idx3", {30'd0, plog[(base + 3) % 1024]}, 1);

    // R8 one-shot and R9 rearm
    stop_sel = 2'd2;
    one_shot = 1'b1;
    do_rearm();
    base = n_pulse;
    repeat (5) pulse(5, 5);
    idle(8);
    chk("R8 stops after stop event", n_pulse - base, 3);
    chk("R8 last index", {30'd0, plog[(base + 2) % 1024]}, 2);
    s0 = stamp_0;
    pulse(5, 5);
    idle(8);
    chk("R8 stamp_0 untouched while frozen", stamp_0, s0);
    do_rearm();
    base = n_pulse;
    pulse(5, 5);
    idle(8);
    chk("R9 restart count", n_pulse - base, 1);
    chk("R9 restart index", {30'd0, plog[base % 1024]}, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule